// File: doc/BRIEF.md
# Debug Bus Access Controller

This block sits between a JTAG transport and a debug module. Each time the transport finishes a scan of the debug-bus data register, the block receives the shifted word on an update strobe and turns it into a read or a write on a simple request/acknowledge bus. The result of the access, and a 2-bit status, are kept in a stored word. The next capture strobe hands this word back so that it can be shifted out.

After every performed access, the host must let a programmed number of Run-Test-Idle ticks pass before it scans again. A capture that comes too early, or while a bus access is still outstanding, returns the busy status and sets a sticky busy flag. While that flag is set, every later capture reports busy and every update is dropped, until the host clears the flag through the transport control register.

The same control register can also perform a hard reset. A hard reset clears the stored word, the idle counter and the sticky flag, and it discards the result of any bus access that is still in flight.

Top module: `dbg_access_ctrl`

## Requirements
- R1: The debug-bus word holds the request op in bits 1:0, data in bits 33:2 and the address from bit 34 upward. Request op 1 is a read and op 2 is a write. Ops 0 and 3 start no bus access; they store the shifted word with op field 0.
- R2: A capture while not busy loads the stored word into `cap_word_o` in the cycle after the strobe.
- R3: A capture while idle ticks are outstanding, while a bus access is pending, or while sticky busy is set loads the value 3 (status busy, all other bits 0) and sets sticky busy. Sticky busy reads back as 3 in `ctrl_rd_o[11:10]`, and as 0 otherwise.
- R4: While sticky busy is set, an update starts no bus access and changes neither the stored word nor the idle counter.
- R5: An accepted read drives `bus_req_o` with `bus_we_o`=0 and the address field on the next cycle. On ack, the data field takes `bus_rdata_i`, and the op field becomes 0 (or 2 if `bus_err_i` is high).
- R6: An accepted write drives `bus_req_o` with `bus_we_o`=1, the address field and the data field on the next cycle. On ack, the op field becomes 0 (or 2 on error).
- R7: Every accepted update reloads the idle counter with `idle_cycles_i`. Each `rti_tick_i` lowers the counter by one while it is above zero. A capture is not busy only once the counter is zero.
- R8: A control write with bit 16 set clears sticky busy.
- R9: A control write with bit 17 set clears sticky busy, zeroes the idle counter and zeroes the stored word. The ack of a bus access that was pending at that moment commits nothing.
- R10: After reset, `cap_word_o` is 0, `bus_req_o` is 0, sticky busy reads 0, `ctrl_rd_o[3:0]` is 1 and `ctrl_rd_o[9:4]` gives the address width.
- R11: `bus_req_o` stays high until the cycle in which `bus_ack_i` is seen. While it is high, address, write data and direction do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_i | input | 1 | Capture strobe for the debug-bus register |
| update_i | input | 1 | Update strobe for the debug-bus register |
| shift_word_i | input | ADDR_W+34 | Word shifted in by the transport |
| ctrl_wr_i | input | 1 | Control register update strobe |
| ctrl_wdata_i | input | 32 | Control register value (bit 16 clear busy, bit 17 hard reset) |
| rti_tick_i | input | 1 | One Run-Test-Idle cycle elapsed |
| idle_cycles_i | input | CNT_W | Required idle ticks after each access |
| cap_word_o | output | ADDR_W+34 | Word captured for shifting out |
| ctrl_rd_o | output | 32 | Control/status readback |
| bus_req_o | output | 1 | Bus request, held until ack |
| bus_we_o | output | 1 | Bus direction, 1 for write |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Bus acknowledge |
| bus_rdata_i | input | 32 | Bus read data, valid with ack |
| bus_err_i | input | 1 | Bus error, valid with ack |

## Verification
The bound checker watches the bus handshake on every cycle: the request is held and its fields stay stable until ack. It also checks on every cycle that a capture during a pending access or under sticky busy yields the busy code, that a sticky flag blocks new requests, that a clear write drops the flag, and that an accepted read or write raises a request carrying the right address and data. The exact idle-tick boundary, the data and status that a completed read or write leaves in the stored word, and the dropped result after a hard reset during an access can only be shown by the bench's scenarios, which compare against a behavioural model on every cycle.

// File: rtl/dac_pkg.sv
// Package dac_pkg
// Shared codes and control-bit positions for the debug bus access controller.
// Assumes the op field occupies the two least significant bits of the word.
package dac_pkg;
    typedef enum logic [1:0] {
        REQ_NOP = 2'd0,
        REQ_RD  = 2'd1,
        REQ_WR  = 2'd2,
        REQ_RSV = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_RSV  = 2'd1,
        ST_FAIL = 2'd2,
        ST_BUSY = 2'd3
    } status_e;

    localparam int CLR_BUSY_BIT = 16;
    localparam int HARD_RST_BIT = 17;
    localparam int DATA_W       = 32;
    localparam int CTRL_W       = 32;
    localparam logic [3:0] CTRL_VERSION = 4'd1;
endpackage

// File: rtl/dac_idle_ctr.sv
// Module dac_idle_ctr
// Counts outstanding Run-Test-Idle ticks after an access.
// Assumes clear has priority over load, and load over tick.
module dac_idle_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on access, count down on ticks, saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dac_bus_master.sv
// Module dac_bus_master
// Runs one request/acknowledge transfer at a time on the debug-module bus.
// Assumes start is only raised while no transfer is pending.
// A kill during a pending transfer lets the handshake finish but suppresses done.
module dac_bus_master #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_we_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [DATA_W-1:0] start_wdata_i,
    input  logic              kill_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i
);
    logic              pend_q;
    logic              drop_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              ack_seen;

    assign ack_seen = pend_q && bus_ack_i;

    // Track the pending transfer and latch its fields at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (ack_seen) begin
            pend_q <= 1'b0;
        end else if (start_i) begin
            pend_q  <= 1'b1;
            we_q    <= start_we_i;
            addr_q  <= start_addr_i;
            wdata_q <= start_wdata_i;
        end
    end

    // Remember that the pending result must be thrown away.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (ack_seen) begin
            drop_q <= 1'b0;
        end else if (kill_i && pend_q) begin
            drop_q <= 1'b1;
        end
    end

    assign busy_o      = pend_q;
    assign done_o      = ack_seen && !drop_q;
    assign bus_req_o   = pend_q;
    assign bus_we_o    = we_q;
    assign bus_addr_o  = addr_q;
    assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/dbg_access_ctrl.sv
// Module dbg_access_ctrl
// Turns completed debug-bus scans into debug-module bus accesses, keeps the
// last request/response word, enforces a minimum idle gap and a sticky busy
// error. Assumes capture/update/control strobes are single-cycle pulses
// already synchronised to clk.
module dbg_access_ctrl #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture_i,
    input  logic                          update_i,
    input  logic [ADDR_W+33:0]            shift_word_i,
    input  logic                          ctrl_wr_i,
    input  logic [dac_pkg::CTRL_W-1:0]    ctrl_wdata_i,
    input  logic                          rti_tick_i,
    input  logic [CNT_W-1:0]              idle_cycles_i,
    output logic [ADDR_W+33:0]            cap_word_o,
    output logic [dac_pkg::CTRL_W-1:0]    ctrl_rd_o,
    output logic                          bus_req_o,
    output logic                          bus_we_o,
    output logic [ADDR_W-1:0]             bus_addr_o,
    output logic [dac_pkg::DATA_W-1:0]    bus_wdata_o,
    input  logic                          bus_ack_i,
    input  logic [dac_pkg::DATA_W-1:0]    bus_rdata_i,
    input  logic                          bus_err_i
);
    import dac_pkg::*;

    localparam int WORD_W  = ADDR_W + 34;
    localparam int DATA_LO = 2;
    localparam int DATA_HI = DATA_LO + DATA_W - 1;
    localparam int ADDR_LO = DATA_HI + 1;

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] cap_q;
    logic              sticky_q;
    logic              idle_zero;
    logic              bm_busy;
    logic              bm_done;
    logic              hard_rst;
    logic              clr_busy;
    logic              busy_now;
    logic              accept;
    logic              is_access;
    req_op_e           req_op;

    assign req_op    = req_op_e'(shift_word_i[1:0]);
    assign is_access = (req_op == REQ_RD) || (req_op == REQ_WR);
    assign hard_rst  = ctrl_wr_i && ctrl_wdata_i[HARD_RST_BIT];
    assign clr_busy  = ctrl_wr_i && (ctrl_wdata_i[CLR_BUSY_BIT] || ctrl_wdata_i[HARD_RST_BIT]);
    assign busy_now  = !idle_zero || bm_busy || sticky_q;
    assign accept    = update_i && !sticky_q && !bm_busy && !hard_rst;

    dac_idle_ctr #(.CNT_W(CNT_W)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (hard_rst),
        .load_i     (accept),
        .load_val_i (idle_cycles_i),
        .tick_i     (rti_tick_i),
        .zero_o     (idle_zero)
    );

    dac_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (accept && is_access),
        .start_we_i    (req_op == REQ_WR),
        .start_addr_i  (shift_word_i[ADDR_LO +: ADDR_W]),
        .start_wdata_i (shift_word_i[DATA_HI:DATA_LO]),
        .kill_i        (hard_rst),
        .busy_o        (bm_busy),
        .done_o        (bm_done),
        .bus_req_o     (bus_req_o),
        .bus_we_o      (bus_we_o),
        .bus_addr_o    (bus_addr_o),
        .bus_wdata_o   (bus_wdata_o),
        .bus_ack_i     (bus_ack_i)
    );

    // Stored request/response word: hard reset, commit result, or accept scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (hard_rst) begin
            word_q <= '0;
        end else if (bm_done) begin
            if (!bus_we_o) begin
                word_q[DATA_HI:DATA_LO] <= bus_rdata_i;
            end
            word_q[1:0] <= bus_err_i ? ST_FAIL : ST_OK;
        end else if (accept) begin
            word_q <= is_access ? shift_word_i
                                : {shift_word_i[WORD_W-1:2], ST_OK};
        end
    end

    // Captured word: busy code when too early, stored word otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (capture_i) begin
            cap_q <= busy_now ? {{(WORD_W-2){1'b0}}, ST_BUSY} : word_q;
        end
    end

    // Sticky busy flag: cleared by control write, set by an early capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= 1'b0;
        end else if (clr_busy) begin
            sticky_q <= 1'b0;
        end else if (capture_i && busy_now) begin
            sticky_q <= 1'b1;
        end
    end

    // Control/status readback fields.
    always_comb begin
        ctrl_rd_o        = '0;
        ctrl_rd_o[3:0]   = CTRL_VERSION;
        ctrl_rd_o[9:4]   = 6'(ADDR_W);
        ctrl_rd_o[11:10] = sticky_q ? ST_BUSY : ST_OK;
    end

    assign cap_word_o = cap_q;
endmodule

// File: rtl/dac_chk.sv
// Module dac_chk
// Property checker for dbg_access_ctrl, observing ports only.
// Assumes sticky busy is visible as ctrl_rd_o[11:10].
module dac_chk #(
    parameter int ADDR_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               capture_i,
    input logic               update_i,
    input logic [ADDR_W+33:0] shift_word_i,
    input logic               ctrl_wr_i,
    input logic [31:0]        ctrl_wdata_i,
    input logic [ADDR_W+33:0] cap_word_o,
    input logic [31:0]        ctrl_rd_o,
    input logic               bus_req_o,
    input logic               bus_we_o,
    input logic [ADDR_W-1:0]  bus_addr_o,
    input logic [31:0]        bus_wdata_o,
    input logic               bus_ack_i
);
    localparam int WORD_W = ADDR_W + 34;

    logic sticky;
    logic ctrl_clear;
    logic ctrl_hard;
    assign sticky     = (ctrl_rd_o[11:10] == 2'b11);
    assign ctrl_hard  = ctrl_wr_i && ctrl_wdata_i[17];
    assign ctrl_clear = ctrl_wr_i && (ctrl_wdata_i[16] || ctrl_wdata_i[17]);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o);

    p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o));

    p_sticky_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sticky && capture_i |=> cap_word_o == WORD_W'(3));

    p_pending_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && capture_i && !ctrl_clear |=> cap_word_o == WORD_W'(3) && ctrl_rd_o[11:10] == 2'b11);

    p_sticky_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sticky && update_i && !bus_req_o |=> !bus_req_o);

    p_read_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky && !bus_req_o && update_i && !ctrl_hard && shift_word_i[1:0] == 2'd1
        |=> bus_req_o && !bus_we_o && bus_addr_o == $past(shift_word_i[WORD_W-1:34]));

    p_write_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky && !bus_req_o && update_i && !ctrl_hard && shift_word_i[1:0] == 2'd2
        |=> bus_req_o && bus_we_o && bus_wdata_o == $past(shift_word_i[33:2]));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clear |=> ctrl_rd_o[11:10] == 2'b00);
endmodule

bind dbg_access_ctrl dac_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_i    (capture_i),
    .update_i     (update_i),
    .shift_word_i (shift_word_i),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .cap_word_o   (cap_word_o),
    .ctrl_rd_o    (ctrl_rd_o),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_ack_i    (bus_ack_i)
);

// File: tb/sim_dbg_access_ctrl.sv
`timescale 1ns/1ps
// Bench for dbg_access_ctrl: behavioural model compared every cycle plus
// directed scenarios with hand-computed expected values.
module sim_dbg_access_ctrl;
    localparam int AW  = 7;
    localparam int CW  = 8;
    localparam int W   = AW + 34;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture_i = 1'b0;
    logic          update_i = 1'b0;
    logic [W-1:0]  shift_word_i = '0;
    logic          ctrl_wr_i = 1'b0;
    logic [31:0]   ctrl_wdata_i = '0;
    logic          rti_tick_i = 1'b0;
    logic [CW-1:0] idle_cycles_i = 8'd3;
    logic [W-1:0]  cap_word_o;
    logic [31:0]   ctrl_rd_o;
    logic          bus_req_o;
    logic          bus_we_o;
    logic [AW-1:0] bus_addr_o;
    logic [31:0]   bus_wdata_o;
    logic          bus_ack_i = 1'b0;
    logic [31:0]   bus_rdata_i = '0;
    logic          bus_err_i = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    dbg_access_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .capture_i(capture_i), .update_i(update_i),
        .shift_word_i(shift_word_i), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
        .rti_tick_i(rti_tick_i), .idle_cycles_i(idle_cycles_i), .cap_word_o(cap_word_o),
        .ctrl_rd_o(ctrl_rd_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
        .bus_rdata_i(bus_rdata_i), .bus_err_i(bus_err_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mkword(input logic [AW-1:0] a, input logic [31:0] d, input logic [1:0] op);
        return {a, d, op};
    endfunction

    // Bus slave: ack after LAT cycles of request; error at address 0x55.
    int slv_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack_i = 1'b0;
            slv_cnt = 0;
        end else if (bus_ack_i) begin
            bus_ack_i = 1'b0;
            slv_cnt = 0;
        end else if (bus_req_o) begin
            slv_cnt++;
            if (slv_cnt >= LAT) begin
                bus_ack_i   = 1'b1;
                bus_rdata_i = 32'hA500_0000 | 32'(bus_addr_o);
                bus_err_i   = (bus_addr_o == 7'h55);
            end
        end
    end

    // Behavioural reference model.
    logic [W-1:0] m_word, m_cap;
    int           m_cnt;
    bit           m_sticky, m_pend, m_drop, m_we;
    bit           m_busy, m_hard, m_clr, m_acc, m_acked;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_cap = '0; m_cnt = 0;
            m_sticky = 0; m_pend = 0; m_drop = 0; m_we = 0;
        end else begin
            m_busy  = (m_cnt != 0) || m_pend || m_sticky;
            m_hard  = ctrl_wr_i && ctrl_wdata_i[17];
            m_clr   = ctrl_wr_i && (ctrl_wdata_i[16] || ctrl_wdata_i[17]);
            m_acc   = update_i && !m_sticky && !m_pend && !m_hard;
            m_acked = m_pend && bus_ack_i;
            if (capture_i) m_cap = m_busy ? W'(3) : m_word;
            if (m_acked) begin
                if (!m_drop) begin
                    if (!m_we) m_word[33:2] = bus_rdata_i;
                    m_word[1:0] = bus_err_i ? 2'd2 : 2'd0;
                end
                m_pend = 0;
                m_drop = 0;
            end
            if (m_hard) begin
                m_word = '0;
                m_cnt = 0;
                if (m_pend) m_drop = 1;
            end else if (m_acc) begin
                if (shift_word_i[1:0] == 2'd1 || shift_word_i[1:0] == 2'd2) begin
                    m_pend = 1;
                    m_we = (shift_word_i[1:0] == 2'd2);
                    m_word = shift_word_i;
                end else begin
                    m_word = {shift_word_i[W-1:2], 2'b00};
                end
                m_cnt = int'(idle_cycles_i);
            end else if (rti_tick_i && m_cnt > 0) begin
                m_cnt--;
            end
            if (m_clr) m_sticky = 0;
            else if (capture_i && m_busy) m_sticky = 1;
        end
    end

    // Per-cycle comparison with the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(cap_word_o == m_cap, "R2 model cap_word", 64'(cap_word_o), 64'(m_cap));
            check(bus_req_o == m_pend, "R11 model bus_req", 64'(bus_req_o), 64'(m_pend));
            check(ctrl_rd_o[11:10] == (m_sticky ? 2'b11 : 2'b00), "R3 model sticky",
                  64'(ctrl_rd_o[11:10]), 64'(m_sticky ? 2'b11 : 2'b00));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_update(input logic [W-1:0] w);
        @(negedge clk); update_i = 1'b1; shift_word_i = w;
        @(negedge clk); update_i = 1'b0;
    endtask

    task automatic do_capture(output logic [W-1:0] v);
        @(negedge clk); capture_i = 1'b1;
        @(negedge clk); capture_i = 1'b0; v = cap_word_o;
    endtask

    task automatic do_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
        @(negedge clk); ctrl_wr_i = 1'b0; ctrl_wdata_i = '0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rti_tick_i = 1'b1;
        end
        @(negedge clk); rti_tick_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!bus_req_o) break;
        end
    endtask

    logic [W-1:0] v;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(cap_word_o == '0, "R10 cap after reset", 64'(cap_word_o), 0);
        check(bus_req_o == 1'b0, "R10 req after reset", 64'(bus_req_o), 0);
        check(ctrl_rd_o == {20'd0, 2'b00, 6'(AW), 4'd1}, "R10 ctrl readback",
              64'(ctrl_rd_o), 64'({20'd0, 2'b00, 6'(AW), 4'd1}));
        // R2: first capture returns stored zero word
        do_capture(v);
        check(v == '0, "R2 initial capture", 64'(v), 0);

        // R6 / R1: write
        do_update(mkword(7'h12, 32'hDEAD_BEEF, 2'd2));
        check(bus_req_o && bus_we_o, "R6 write request", 64'({bus_req_o, bus_we_o}), 64'h3);
        check(bus_addr_o == 7'h12, "R1 write address field", 64'(bus_addr_o), 64'h12);
        check(bus_wdata_o == 32'hDEAD_BEEF, "R6 write data", 64'(bus_wdata_o), 64'hDEADBEEF);
        wait_done();
        do_ticks(3);
        do_capture(v);
        check(v == mkword(7'h12, 32'hDEAD_BEEF, 2'd0), "R6 write result", 64'(v),
              64'(mkword(7'h12, 32'hDEAD_BEEF, 2'd0)));

        // R5: read success
        do_update(mkword(7'h21, 32'h0, 2'd1));
        check(bus_req_o && !bus_we_o && bus_addr_o == 7'h21, "R5 read request",
              64'({bus_req_o, bus_we_o, bus_addr_o}), 64'({1'b1, 1'b0, 7'h21}));
        wait_done();
        do_ticks(3);
        do_capture(v);
        check(v == mkword(7'h21, 32'hA500_0021, 2'd0), "R5 read data", 64'(v),
              64'(mkword(7'h21, 32'hA500_0021, 2'd0)));

        // R5: read error
        do_update(mkword(7'h55, 32'h1234, 2'd1));
        wait_done();
        do_ticks(3);
        do_capture(v);
        check(v == mkword(7'h55, 32'hA500_0055, 2'd2), "R5 read failed status", 64'(v),
              64'(mkword(7'h55, 32'hA500_0055, 2'd2)));

        // R3 / R7: early capture after only 2 of 3 ticks
        do_update(mkword(7'h21, 32'h0, 2'd1));
        wait_done();
        do_ticks(2);
        do_capture(v);
        check(v == W'(3), "R7 early capture busy", 64'(v), 3);
        check(ctrl_rd_o[11:10] == 2'b11, "R3 sticky readback", 64'(ctrl_rd_o[11:10]), 3);
        // R4: update under sticky ignored
        do_update(mkword(7'h40, 32'h5555, 2'd2));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!bus_req_o, "R4 no request while sticky", 64'(bus_req_o), 0);
        end
        do_ticks(5);
        do_capture(v);
        check(v == W'(3), "R3 sticky persists", 64'(v), 3);
        // R8: clear
        do_ctrl(32'h0001_0000);
        check(ctrl_rd_o[11:10] == 2'b00, "R8 sticky cleared", 64'(ctrl_rd_o[11:10]), 0);
        do_capture(v);
        check(v == mkword(7'h21, 32'hA500_0021, 2'd0), "R4 stored word unchanged", 64'(v),
              64'(mkword(7'h21, 32'hA500_0021, 2'd0)));

        // R1 / R7: nop stores word with op 0, reloads counter, exact boundary
        do_update(mkword(7'h0A, 32'hCAFE_0001, 2'd0));
        @(negedge clk);
        check(!bus_req_o, "R1 nop no request", 64'(bus_req_o), 0);
        do_ticks(2);
        do_capture(v);
        check(v == W'(3), "R7 busy with one tick left", 64'(v), 3);
        do_ctrl(32'h0001_0000);
        do_ticks(1);
        do_capture(v);
        check(v == mkword(7'h0A, 32'hCAFE_0001, 2'd0), "R7 ready at zero / R1 nop word", 64'(v),
              64'(mkword(7'h0A, 32'hCAFE_0001, 2'd0)));
        // R1: reserved op no request, op field 0
        do_update(mkword(7'h0B, 32'h77, 2'd3));
        @(negedge clk);
        check(!bus_req_o, "R1 reserved no request", 64'(bus_req_o), 0);
        do_ticks(3);
        do_capture(v);
        check(v == mkword(7'h0B, 32'h77, 2'd0), "R1 reserved stored", 64'(v),
              64'(mkword(7'h0B, 32'h77, 2'd0)));

        // R9: hard reset during pending read
        do_update(mkword(7'h33, 32'h0, 2'd1));
        ctrl_wr_i = 1'b1; ctrl_wdata_i = 32'h0002_0000;
        @(negedge clk); ctrl_wr_i = 1'b0; ctrl_wdata_i = '0;
        wait_done();
        @(negedge clk);
        check(ctrl_rd_o[11:10] == 2'b00, "R9 sticky clear after hard reset", 64'(ctrl_rd_o[11:10]), 0);
        do_capture(v);
        check(v == '0, "R9 stored word zero, ack dropped", 64'(v), 0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule